// File: doc/BRIEF.md
# Compare timer array with shared 16-bit counter

The block holds one 16-bit up-counter and five compare channels. Each channel watches the shared count and raises its own sticky flag when the count reaches the 16-bit value that software has loaded into it. Software writes every register over a one-cycle write strobe and reads any of them back through a combinational read port. The counter only advances on a clock-enable pulse while the run bit is set, and it raises a sticky overflow flag when it wraps.

A channel acts as a software timer only when both its compare-enable bit and its match bit are set. The 16-bit compare value is loaded as two bytes. Writing the low byte disarms the channel's comparator, and writing the high byte arms it again. A half-written value therefore never produces a match. A single interrupt line combines the overflow flag with every channel flag whose interrupt-enable bit is set, and a global enable input gates that line.

Top module: `pca_cmp_timer`

## Requirements
- R1: After reset, the counter, the run bit, all flags, all mode registers and all compare bytes read as zero, every comparator is disarmed, and `irq_o` is 0.
- R2: The counter increments by one on each clock edge where `ce_i` is 1 and the run bit (status bit 6) is 1. Otherwise it holds its value.
- R3: On the increment from 0xFFFF to 0x0000, the overflow flag (status bit 7) is set in the same clock edge.
- R4: Channel n's mode register at address 8+n stores bits 6..0 and reads bit 7 as 0. Bit 6 is compare-enable, bit 3 is match and bit 0 is interrupt-enable. A channel can set its flag only when bits 6 and 3 are both 1.
- R5: When an armed and enabled channel n finds the count equal to its {high, low} compare bytes, status bit n is set on the next clock edge.
- R6: A write to channel n's low compare byte (address 16+2n) disarms its comparator. A write to its high byte (address 17+2n) arms it again.
- R7: The status register at address 0 reads as {overflow, run, 0, flag4..flag0}. A write loads the run bit from data bit 6. A flag bit is cleared by writing 0 to it and is left unchanged by writing 1. A hardware set wins over a clear in the same cycle.
- R8: `irq_o` equals `ea_i` AND (overflow flag OR any channel whose flag and interrupt-enable bit are both 1).
- R9: A channel's flag is set only on the first cycle of an equality. When the counter is stopped on the compare value, a flag that has been cleared stays cleared.
- R10: The read port returns the count low and high bytes at addresses 1 and 2, and the compare bytes at the addresses given in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_i | input | 1 | Count enable pulse, taking the place of a prescaler |
| ea_i | input | 1 | Global interrupt enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 5 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench loads a low compare byte alone, steps the counter onto the half-written value and checks for silence. A comparator that stayed armed would flag that false match there. It stops the counter on a compare value and clears the flag. A level-sensitive comparator would set the flag again at once, and a clear that ignored written ones would lose the flag even when software wrote a 1 to it. It also runs channels that have only one of the two enable bits set, and a channel with its interrupt enable off, to catch a wrong gating term. Finally it runs the counter through the 0xFFFF wrap to check the timing of the overflow flag and its path to the interrupt.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int unsigned PCA_NUM_MOD = 5;
  localparam int unsigned PCA_DATA_W  = 8;
  localparam int unsigned PCA_ADDR_W  = 5;
  localparam int unsigned PCA_MODE_W  = 7;

  // mode register bit positions
  localparam int unsigned MB_ECOM = 6;
  localparam int unsigned MB_MAT  = 3;
  localparam int unsigned MB_ECCF = 0;

  // status/control bit positions
  localparam int unsigned CB_CF = 7;
  localparam int unsigned CB_CR = 6;

  // address map
  localparam int unsigned ADDR_CTL    = 0;
  localparam int unsigned ADDR_CNT_LO = 1;
  localparam int unsigned ADDR_CNT_HI = 2;
  localparam int unsigned ADDR_MODE0  = 8;
  localparam int unsigned ADDR_CMP0   = 16;

  typedef logic [PCA_MODE_W-1:0] pca_mode_t;
endpackage

// File: rtl/pca_counter.sv
module pca_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pca_cmp_chan.sv
module pca_cmp_chan
  import pca_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_mode_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output pca_mode_t         mode_o,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              hit_o
);
  pca_mode_t         mode_q, mode_d;
  logic [DATA_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic              cen_q, cen_d;
  logic              eq_q, eq_d;
  logic              armed;

  always_comb begin
    mode_d = mode_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    cen_d  = cen_q;
    if (wr_mode_i) mode_d = wr_data_i[PCA_MODE_W-1:0];
    if (wr_lo_i) begin
      lo_d  = wr_data_i;
      cen_d = 1'b0;
    end
    if (wr_hi_i) begin
      hi_d  = wr_data_i;
      cen_d = 1'b1;
    end
  end

  assign armed = cen_q && mode_q[MB_ECOM] && mode_q[MB_MAT];
  assign eq_d  = armed && (cnt_i == {hi_q, lo_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      cen_q  <= 1'b0;
      eq_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      cen_q  <= cen_d;
      eq_q   <= eq_d;
    end
  end

  assign hit_o  = eq_d && !eq_q;
  assign mode_o = mode_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/pca_flags.sv
module pca_flags #(
  parameter int unsigned NUM_MOD = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_ctl_i,
  input  logic               wd_cf_i,
  input  logic               wd_cr_i,
  input  logic [NUM_MOD-1:0] wd_ccf_i,
  input  logic [NUM_MOD-1:0] hit_i,
  input  logic               wrap_i,
  output logic               cf_o,
  output logic               cr_o,
  output logic [NUM_MOD-1:0] ccf_o
);
  logic               cf_q, cf_d, cr_q, cr_d;
  logic [NUM_MOD-1:0] ccf_q, ccf_d, clr;

  assign clr = wr_ctl_i ? ~wd_ccf_i : '0;

  always_comb begin
    cr_d  = wr_ctl_i ? wd_cr_i : cr_q;
    cf_d  = wrap_i | (cf_q & ~(wr_ctl_i & ~wd_cf_i));
    ccf_d = hit_i | (ccf_q & ~clr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cf_q  <= 1'b0;
      cr_q  <= 1'b0;
      ccf_q <= '0;
    end else begin
      cf_q  <= cf_d;
      cr_q  <= cr_d;
      ccf_q <= ccf_d;
    end
  end

  assign cf_o  = cf_q;
  assign cr_o  = cr_q;
  assign ccf_o = ccf_q;
endmodule

// File: rtl/pca_cmp_timer.sv
module pca_cmp_timer
  import pca_pkg::*;
#(
  parameter int unsigned NUM_MOD = PCA_NUM_MOD,
  parameter int unsigned DATA_W  = PCA_DATA_W,
  parameter int unsigned ADDR_W  = PCA_ADDR_W,
  localparam int unsigned CNT_W  = 2 * DATA_W,
  localparam int unsigned PAD_W  = DATA_W - 2 - NUM_MOD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              ea_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [1:0]               rst_sync_q;
  logic                     rst_n;
  logic [CNT_W-1:0]         cnt;
  logic                     wrap, tick;
  logic                     cf, cr, wr_ctl;
  logic [NUM_MOD-1:0]       ccf, hit, eccf;
  pca_mode_t                mode_w [NUM_MOD];
  logic [DATA_W-1:0]        lo_w   [NUM_MOD];
  logic [DATA_W-1:0]        hi_w   [NUM_MOD];
  logic [NUM_MOD*CNT_W-1:0] cmp_flat;
  logic [DATA_W-1:0]        ctl_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign tick   = ce_i && cr;
  assign wr_ctl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTL));

  pca_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .tick_i(tick),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  for (genvar n = 0; n < NUM_MOD; n++) begin : g_chan
    logic wr_mode, wr_lo, wr_hi;
    assign wr_mode = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MODE0 + n));
    assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMP0 + 2 * n));
    assign wr_hi   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CMP0 + 2 * n + 1));

    pca_cmp_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .wr_mode_i(wr_mode),
      .wr_lo_i  (wr_lo),
      .wr_hi_i  (wr_hi),
      .wr_data_i(wr_data_i),
      .cnt_i    (cnt),
      .mode_o   (mode_w[n]),
      .lo_o     (lo_w[n]),
      .hi_o     (hi_w[n]),
      .hit_o    (hit[n])
    );

    assign eccf[n] = mode_w[n][MB_ECCF];
    assign cmp_flat[n*CNT_W +: CNT_W] = {hi_w[n], lo_w[n]};
  end

  pca_flags #(.NUM_MOD(NUM_MOD)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .wr_ctl_i(wr_ctl),
    .wd_cf_i (wr_data_i[CB_CF]),
    .wd_cr_i (wr_data_i[CB_CR]),
    .wd_ccf_i(wr_data_i[NUM_MOD-1:0]),
    .hit_i   (hit),
    .wrap_i  (wrap),
    .cf_o    (cf),
    .cr_o    (cr),
    .ccf_o   (ccf)
  );

  assign ctl_byte = {cf, cr, {PAD_W{1'b0}}, ccf};

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_CTL))    rd_data_o = ctl_byte;
    if (rd_addr_i == ADDR_W'(ADDR_CNT_LO)) rd_data_o = cnt[DATA_W-1:0];
    if (rd_addr_i == ADDR_W'(ADDR_CNT_HI)) rd_data_o = cnt[CNT_W-1:DATA_W];
    for (int n = 0; n < NUM_MOD; n++) begin
      if (rd_addr_i == ADDR_W'(ADDR_MODE0 + n))
        rd_data_o = DATA_W'(mode_w[n]);
      if (rd_addr_i == ADDR_W'(ADDR_CMP0 + 2 * n))
        rd_data_o = lo_w[n];
      if (rd_addr_i == ADDR_W'(ADDR_CMP0 + 2 * n + 1))
        rd_data_o = hi_w[n];
    end
  end

  assign irq_o = ea_i && (cf || |(ccf & eccf));
endmodule

// File: rtl/pca_cmp_timer_chk.sv
module pca_cmp_timer_chk
  import pca_pkg::*;
#(
  parameter int unsigned NUM_MOD = 5,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 5,
  localparam int unsigned CNT_W  = 2 * DATA_W
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ce,
  input logic                     ea,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic [CNT_W-1:0]         cnt,
  input logic [DATA_W-1:0]        ctl,
  input logic [NUM_MOD*CNT_W-1:0] cmp_flat,
  input logic                     irq
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && ctl[CB_CR]) |=> $stable(cnt));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ctl[CB_CR]) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r3_wrap_sets_cf: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && ctl[CB_CR] && cnt == {CNT_W{1'b1}}) |=> ctl[CB_CF]);

  a_r8_ea_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |-> !irq);

  for (genvar n = 0; n < NUM_MOD; n++) begin : g_mod
    a_r5_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl[n]) |-> $past(cnt == cmp_flat[n*CNT_W +: CNT_W]));

    a_r6_low_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(ADDR_CMP0 + 2 * n)) |=> !$rose(ctl[n]));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[n] && !(wr_en && wr_addr == ADDR_W'(ADDR_CTL) && !wr_data[n]))
        |=> ctl[n]);
  end
endmodule

bind pca_cmp_timer pca_cmp_timer_chk #(
  .NUM_MOD(NUM_MOD),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk     (clk_i),
  .rst_n   (rst_n),
  .ce      (ce_i),
  .ea      (ea_i),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .wr_data (wr_data_i),
  .cnt     (cnt),
  .ctl     (ctl_byte),
  .cmp_flat(cmp_flat),
  .irq     (irq_o)
);

// File: tb/pca_cmp_timer_tb_top.sv
module pca_cmp_timer_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_i = 1'b0;
  logic       ea_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [4:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [4:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  pca_cmp_timer dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_i     (ce_i),
    .ea_i     (ea_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o),
    .irq_o    (irq_o)
  );

  // {write, addr[4:0], data[7:0], expected read[7:0]}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 5'h00, 8'h00, 8'h00},  // R1 status after reset
    {1'b1, 5'h08, 8'hFF, 8'h00},
    {1'b0, 5'h08, 8'h00, 8'h7F},  // R4 bit 7 reads 0
    {1'b1, 5'h08, 8'h00, 8'h00},
    {1'b0, 5'h08, 8'h00, 8'h00},
    {1'b1, 5'h10, 8'h34, 8'h00},
    {1'b1, 5'h11, 8'h12, 8'h00},
    {1'b0, 5'h10, 8'h00, 8'h34},  // R10 low byte
    {1'b0, 5'h11, 8'h00, 8'h12},  // R10 high byte
    {1'b1, 5'h00, 8'h40, 8'h00},
    {1'b0, 5'h00, 8'h00, 8'h40},  // R7 run bit
    {1'b1, 5'h00, 8'h00, 8'h00},
    {1'b0, 5'h00, 8'h00, 8'h00},
    {1'b0, 5'h01, 8'h00, 8'h00}   // R10 count low
  };

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic rd_cnt(output logic [15:0] c);
    logic [7:0] lo, hi;
    rd(5'h01, lo);
    rd(5'h02, hi);
    c = {hi, lo};
  endtask

  task automatic pulse(input int k);
    @(negedge clk_i);
    ce_i = 1'b1;
    repeat (k) @(negedge clk_i);
    ce_i = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : main
    logic [7:0]  d;
    logic [15:0] c;
    idle(3);
    rst_ni = 1'b1;
    idle(4);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][21]) wr(VEC[i][20:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][20:16], d);
        chk($sformatf("R10/R1/R4/R7 vector %0d", i), {8'h00, d}, {8'h00, VEC[i][7:0]});
      end
    end
    ea_i = 1'b1;

    // R2: run bit clear blocks counting
    pulse(5);
    rd_cnt(c); chk("R2 stopped by run bit", c, 16'd0);
    wr(5'h00, 8'h40);
    pulse(7);
    rd_cnt(c); chk("R2 seven steps", c, 16'd7);
    idle(3);
    rd_cnt(c); chk("R2 hold without ce", c, 16'd7);

    // R5/R8: channel 1 matches at 12
    wr(5'h09, 8'h49);
    wr(5'h12, 8'd12);
    wr(5'h13, 8'h00);
    pulse(4);
    idle(1);
    rd(5'h00, d); chk("R5 no flag before value", {8'h0, d}, 16'h0040);
    chk("R8 irq idle", {15'h0, irq_o}, 16'h0);
    pulse(1);
    idle(1);
    rd(5'h00, d); chk("R5 flag on match", {8'h0, d}, 16'h0042);
    chk("R8 irq from flag", {15'h0, irq_o}, 16'h1);
    ea_i = 1'b0; #1;
    chk("R8 irq gated by ea", {15'h0, irq_o}, 16'h0);
    ea_i = 1'b1;

    // R7/R9: write 1 keeps, write 0 clears, no re-fire while equal
    wr(5'h00, 8'h5F);
    rd(5'h00, d); chk("R7 write one keeps flag", {8'h0, d}, 16'h0042);
    wr(5'h00, 8'h40);
    idle(3);
    rd(5'h00, d); chk("R9 no re-set while equal", {8'h0, d}, 16'h0040);
    chk("R9 irq stays low", {15'h0, irq_o}, 16'h0);

    // R4: one enable bit alone is not enough (channels 2, 3 at 14)
    wr(5'h0A, 8'h41); wr(5'h14, 8'd14); wr(5'h15, 8'h00);
    wr(5'h0B, 8'h09); wr(5'h16, 8'd14); wr(5'h17, 8'h00);
    pulse(2);
    idle(1);
    rd(5'h00, d); chk("R4 partial mode no flag", {8'h0, d}, 16'h0040);

    // R8: channel 4 flags at 16 without interrupt enable
    wr(5'h0C, 8'h48); wr(5'h18, 8'd16); wr(5'h19, 8'h00);
    pulse(2);
    idle(1);
    rd(5'h00, d); chk("R5 flag4 set", {8'h0, d}, 16'h0050);
    chk("R8 eccf off no irq", {15'h0, irq_o}, 16'h0);
    wr(5'h00, 8'h40);

    // R6: low write alone disarms, full pair re-arms (channel 0)
    wr(5'h08, 8'h49);
    wr(5'h11, 8'h00);
    wr(5'h10, 8'd19);
    pulse(3);
    idle(1);
    rd(5'h00, d); chk("R6 low write disarms", {8'h0, d}, 16'h0040);
    pulse(1);
    wr(5'h10, 8'd23);
    wr(5'h11, 8'h00);
    pulse(3);
    idle(1);
    rd(5'h00, d); chk("R6 high write re-arms", {8'h0, d}, 16'h0041);
    chk("R8 irq channel0", {15'h0, irq_o}, 16'h1);
    wr(5'h00, 8'h40);

    // R3: wrap
    pulse(65535 - 23);
    rd_cnt(c); chk("R3 count at top", c, 16'hFFFF);
    rd(5'h00, d); chk("R3 no overflow yet", {8'h0, d}, 16'h0040);
    pulse(1);
    rd_cnt(c); chk("R3 count wrapped", c, 16'h0000);
    rd(5'h00, d); chk("R3 overflow set", {8'h0, d}, 16'h00C0);
    chk("R8 irq from overflow", {15'h0, irq_o}, 16'h1);
    wr(5'h00, 8'h40);
    rd(5'h00, d); chk("R7 overflow cleared", {8'h0, d}, 16'h0040);
    chk("R8 irq cleared", {15'h0, irq_o}, 16'h0);

    // R1: reset mid-run
    pulse(3);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    rd(5'h00, d); chk("R1 status reset", {8'h0, d}, 16'h0000);
    rd_cnt(c);    chk("R1 count reset", c, 16'h0000);
    rd(5'h09, d); chk("R1 mode reset", {8'h0, d}, 16'h0000);
    rd(5'h12, d); chk("R1 compare reset", {8'h0, d}, 16'h0000);
    chk("R1 irq reset", {15'h0, irq_o}, 16'h0);
    idle(2);
    rst_ni = 1'b1;
    idle(4);

    done = 1'b1;
    report();
  end
endmodule